// File: doc/BRIEF.md
# Runtime-Reconfigurable Debug Probe Multiplexer

This block lets a small number of debug output pins observe a wide bus of internal signals. Each pin is fed by a table of probe selections, one per time slot. On every sample tick the pin shows the probe chosen for the current slot, and the slot then advances. All pins share a programmable frame length of N slots, where N can be anything from 1 to the maximum. A short frame gives each observed signal a high sample rate. A long frame lets one pin carry many signals.

Software changes the selection tables, the frame length and the event detector through a simple write port while the design keeps running. Selection and frame-length writes are first held in a shadow copy. That copy becomes live only when a frame ends, so no frame ever mixes two mappings.

An on-chip event detector picks a few probe signals of its own. On each tick it compares them, under a mask, with a programmed value. Once armed, it pulses a trigger on the first matching tick and then stays silent until it is armed again. The sample tick is a clock enable. It is meant to run at roughly twice the rate of the observed logic. The pin outputs are free running: `pin_valid` marks fresh data, and there is no ready input, because the debug pins cannot push back. A tick is never stalled.

Top module: `probe_mux`

## Requirements
- R1: After reset the pins, `pin_valid`, `frame_start` and `trig` are 0. Every selection entry holds the all-ones code, which is out of range. The frame length is 1 and the detector is disarmed with mask 0.
- R2: A tick with `sample_en`=1 at a clock edge makes each pin show, from the next cycle, the value of `probe_in` at that edge at the index held in its live entry for the current slot. `pin_valid` is 1 for exactly that one cycle. Without a tick the pins hold their value.
- R3: The shared slot counter runs 0,1,…,N-1 and then back to 0, moving by one per tick. N is the frame-length field plus 1. A written field larger than MAX_RATIO-1 saturates to MAX_RATIO-1.
- R4: `frame_start` is 1 exactly while the pins show slot-0 data. Like the pins, it changes only on a tick.
- R5: A selection code of PROBE_W or above reads as constant 0. This holds for pin entries and for detector taps.
- R6: Writes to selection entries and to the frame length go to a shadow copy. The shadow is copied into the live set after the tick that drives slot N-1, and only if a write is pending. The tick that is in flight still uses the old set.
- R7: Any probe index from 0 to PROBE_W-1 can be routed to any pin in any slot.
- R8: The detector match is ((taps XOR value) AND mask) == 0, sampled on a tick. If the detector is armed, a match sets `trig` for exactly the following cycle and disarms the detector.
- R9: The detector is armed only by a write to its arm register. While it is disarmed, `trig` stays 0 whatever the probes do. Writes to taps, mask and value take effect at once.
- R10: Write address map. When the top address bit is 0, the write targets selection entry pin*MAX_RATIO+slot. When it is 1, the low bits select a control register: 0 is the frame length minus 1, 1 is the mask, 2 is the value, 3 is arm, and 4+k is the selection code of tap k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| probe_in | input | PROBE_W | Internal signals offered for observation |
| sample_en | input | 1 | Sample tick (clock enable) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration write address |
| cfg_wdata | input | CFG_DW | Configuration write data |
| pin_out | output | PINS | Debug pin values |
| pin_valid | output | 1 | High for the cycle after each tick |
| frame_start | output | 1 | Pins carry slot-0 data |
| trig | output | 1 | One-cycle event trigger |

## Verification
The bench builds the block with PROBE_W=16, PINS=2, MAX_RATIO=8 and DET_W=4. This makes the selection codes 5 bits wide, so half of all codes are out of range. At that size the bench can sweep every frame length from 1 to 8, including a saturating write. Each sweep reprograms every entry of both pins and runs several frames, which exercises the commit point at every length. The small detector lets a masked compare with an out-of-range tap match often enough to show repeated firing and re-arming within a few dozen ticks.

// File: rtl/probe_mux_pkg.sv
package probe_mux_pkg;
  // control register offsets inside the control half of the address space
  localparam int CTL_RATIO = 0;
  localparam int CTL_MASK  = 1;
  localparam int CTL_VALUE = 2;
  localparam int CTL_ARM   = 3;
  localparam int CTL_TAP0  = 4;
  localparam int CTL_FIXED = 4;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/probe_map_store.sv
module probe_map_store #(
  parameter int PINS      = 4,
  parameter int MAX_RATIO = 64,
  parameter int SEL_W     = 9,
  parameter int SLOT_W    = 6,
  parameter int MAP_AW    = 8,
  parameter int CFG_DW    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   map_we,
  input  logic [MAP_AW-1:0]      map_idx,
  input  logic                   ratio_we,
  input  logic [CFG_DW-1:0]      wdata,
  output logic [PINS*SEL_W-1:0]  sel_flat,
  output logic [SLOT_W-1:0]      slot_q,
  output logic [SLOT_W-1:0]      ratio_act
);
  localparam int MAP_N = PINS * MAX_RATIO;

  logic [SEL_W-1:0]  shd_map [MAP_N];
  logic [SEL_W-1:0]  act_map [MAP_N];
  logic [SLOT_W-1:0] ratio_shd;
  logic              pending;
  logic              last_slot;

  assign last_slot = (slot_q == ratio_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAP_N; i++) begin
        shd_map[i] <= '1;
        act_map[i] <= '1;
      end
      ratio_shd <= '0;
      ratio_act <= '0;
      pending   <= 1'b0;
      slot_q    <= '0;
    end else begin
      if (map_we && (int'(map_idx) < MAP_N))
        shd_map[map_idx] <= wdata[SEL_W-1:0];
      if (ratio_we) begin
        if (wdata > CFG_DW'(MAX_RATIO - 1)) ratio_shd <= SLOT_W'(MAX_RATIO - 1);
        else                               ratio_shd <= wdata[SLOT_W-1:0];
      end
      if (tick) begin
        if (last_slot) begin
          slot_q <= '0;
          if (pending) begin
            act_map   <= shd_map;
            ratio_act <= ratio_shd;
          end
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
      if (map_we || ratio_we)        pending <= 1'b1;
      else if (tick && last_slot)    pending <= 1'b0;
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_sel
    assign sel_flat[p*SEL_W +: SEL_W] = act_map[MAP_AW'(p * MAX_RATIO) + MAP_AW'(slot_q)];
  end
endmodule

// File: rtl/probe_lane.sv
module probe_lane #(
  parameter int PROBE_W = 256,
  parameter int SEL_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PROBE_W-1:0] probe_in,
  input  logic [SEL_W-1:0]   sel,
  output logic               q
);
  localparam int EXT_W = 2 ** SEL_W;

  logic [EXT_W-1:0] ext;
  assign ext = {{(EXT_W - PROBE_W){1'b0}}, probe_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (tick) q <= ext[sel];
  end
endmodule

// File: rtl/probe_event_det.sv
module probe_event_det #(
  parameter int PROBE_W = 256,
  parameter int SEL_W   = 9,
  parameter int DET_W   = 8,
  parameter int TAP_AW  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PROBE_W-1:0] probe_in,
  input  logic               mask_we,
  input  logic               value_we,
  input  logic               arm_we,
  input  logic               tap_we,
  input  logic [TAP_AW-1:0]  tap_idx,
  input  logic [DET_W-1:0]   field_wdata,
  input  logic [SEL_W-1:0]   sel_wdata,
  output logic               armed,
  output logic               trig
);
  localparam int EXT_W = 2 ** SEL_W;

  logic [EXT_W-1:0] ext;
  logic [SEL_W-1:0] tap_sel [DET_W];
  logic [DET_W-1:0] taps, mask_q, value_q;
  logic             fire;

  assign ext = {{(EXT_W - PROBE_W){1'b0}}, probe_in};

  for (genvar k = 0; k < DET_W; k++) begin : g_tap
    assign taps[k] = ext[tap_sel[k]];
  end

  assign fire = tick && armed && (((taps ^ value_q) & mask_q) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DET_W; k++) tap_sel[k] <= '1;
      mask_q  <= '0;
      value_q <= '0;
      armed   <= 1'b0;
      trig    <= 1'b0;
    end else begin
      if (tap_we && (int'(tap_idx) < DET_W)) tap_sel[tap_idx] <= sel_wdata;
      if (mask_we)  mask_q  <= field_wdata;
      if (value_we) value_q <= field_wdata;
      if (arm_we)     armed <= 1'b1;
      else if (fire)  armed <= 1'b0;
      trig <= fire;
    end
  end
endmodule

// File: rtl/probe_mux.sv
module probe_mux
  import probe_mux_pkg::*;
#(
  parameter int PROBE_W   = 256,
  parameter int PINS      = 4,
  parameter int MAX_RATIO = 64,   // power of two
  parameter int DET_W     = 8,
  parameter int CFG_DW    = 16,
  localparam int SEL_W    = $clog2(PROBE_W) + 1,
  localparam int SLOT_W   = max_int($clog2(MAX_RATIO), 1),
  localparam int MAP_AW   = max_int($clog2(PINS * MAX_RATIO), 1),
  localparam int CTL_AW   = $clog2(CTL_FIXED + DET_W),
  localparam int ADDR_W   = max_int(MAP_AW, CTL_AW) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PROBE_W-1:0] probe_in,
  input  logic               sample_en,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  output logic [PINS-1:0]    pin_out,
  output logic               pin_valid,
  output logic               frame_start,
  output logic               trig
);
  localparam int TAP_AW = max_int($clog2(DET_W), 1);

  logic              in_ctl;
  logic [CTL_AW-1:0] sub;
  logic              map_we, ratio_we, mask_we, value_we, arm_we, tap_we;
  logic [TAP_AW-1:0] tap_idx;
  logic [PINS*SEL_W-1:0] sel_flat;
  logic [SLOT_W-1:0] slot_q, ratio_act;
  logic              det_armed;

  assign in_ctl   = cfg_addr[ADDR_W-1];
  assign sub      = cfg_addr[CTL_AW-1:0];
  assign map_we   = cfg_we && !in_ctl;
  assign ratio_we = cfg_we && in_ctl && (sub == CTL_AW'(CTL_RATIO));
  assign mask_we  = cfg_we && in_ctl && (sub == CTL_AW'(CTL_MASK));
  assign value_we = cfg_we && in_ctl && (sub == CTL_AW'(CTL_VALUE));
  assign arm_we   = cfg_we && in_ctl && (sub == CTL_AW'(CTL_ARM));
  assign tap_we   = cfg_we && in_ctl && (int'(sub) >= CTL_TAP0) && (int'(sub) < CTL_TAP0 + DET_W);
  assign tap_idx  = TAP_AW'(int'(sub) - CTL_TAP0);

  probe_map_store #(
    .PINS(PINS), .MAX_RATIO(MAX_RATIO), .SEL_W(SEL_W),
    .SLOT_W(SLOT_W), .MAP_AW(MAP_AW), .CFG_DW(CFG_DW)
  ) i_store (
    .clk(clk), .rst_n(rst_n), .tick(sample_en),
    .map_we(map_we), .map_idx(cfg_addr[MAP_AW-1:0]),
    .ratio_we(ratio_we), .wdata(cfg_wdata),
    .sel_flat(sel_flat), .slot_q(slot_q), .ratio_act(ratio_act)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_lane
    probe_lane #(.PROBE_W(PROBE_W), .SEL_W(SEL_W)) i_lane (
      .clk(clk), .rst_n(rst_n), .tick(sample_en), .probe_in(probe_in),
      .sel(sel_flat[p*SEL_W +: SEL_W]), .q(pin_out[p])
    );
  end

  probe_event_det #(
    .PROBE_W(PROBE_W), .SEL_W(SEL_W), .DET_W(DET_W), .TAP_AW(TAP_AW)
  ) i_det (
    .clk(clk), .rst_n(rst_n), .tick(sample_en), .probe_in(probe_in),
    .mask_we(mask_we), .value_we(value_we), .arm_we(arm_we),
    .tap_we(tap_we), .tap_idx(tap_idx),
    .field_wdata(cfg_wdata[DET_W-1:0]), .sel_wdata(cfg_wdata[SEL_W-1:0]),
    .armed(det_armed), .trig(trig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_valid   <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      pin_valid <= sample_en;
      if (sample_en) frame_start <= (slot_q == '0);
    end
  end
endmodule

// File: rtl/probe_mux_chk.sv
module probe_mux_chk #(
  parameter int PINS   = 4,
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_en,
  input logic [PINS-1:0]   pin_out,
  input logic              pin_valid,
  input logic              frame_start,
  input logic              trig,
  input logic [SLOT_W-1:0] slot_q,
  input logic [SLOT_W-1:0] ratio_act,
  input logic              det_armed
);
  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= ratio_act);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> (!pin_valid && $stable(pin_out) && $stable(frame_start)));

  // R4
  frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_valid && frame_start) |-> ($past(slot_q) == '0));

  // R6
  ratio_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_act) |-> ($past(sample_en) && ($past(slot_q) == $past(ratio_act))));

  // R8
  trig_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> ($past(det_armed) && $past(sample_en)));
endmodule

bind probe_mux probe_mux_chk #(.PINS(PINS), .SLOT_W(SLOT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .pin_out(pin_out),
  .pin_valid(pin_valid), .frame_start(frame_start), .trig(trig),
  .slot_q(slot_q), .ratio_act(ratio_act), .det_armed(det_armed)
);

// File: tb/test_probe_mux.sv
module test_probe_mux;
  localparam int PW = 16, NP = 2, MR = 8, DW = 4, CW = 16;
  localparam int AW = 5;            // max(4,3)+1
  localparam int CTL = 16;          // control half base

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PW-1:0] probe_in = '0;
  logic sample_en = 1'b0, cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [NP-1:0] pin_out;
  logic pin_valid, frame_start, trig;

  always #4 clk = ~clk;   // 125 MHz

  probe_mux #(.PROBE_W(PW), .PINS(NP), .MAX_RATIO(MR), .DET_W(DW), .CFG_DW(CW)) i_probe_mux (
    .clk(clk), .rst_n(rst_n), .probe_in(probe_in), .sample_en(sample_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pin_out(pin_out), .pin_valid(pin_valid), .frame_start(frame_start), .trig(trig)
  );

  int checks = 0, fails = 0, kcount = 0, fires_seen = 0;
  bit done = 1'b0;

  // bench-side model, built from the requirements
  int shd [16], act [16], taps_m [4];
  int rshd = 0, ract = 0, slot_m = 0, mask_m = 0, value_m = 0;
  bit pend = 0, armed_m = 0;
  logic [NP-1:0] last_pins = '0;

  task automatic check(input bit ok, input string req, input int a, input int e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  function automatic logic [15:0] pat(input int k);
    return 16'(k * 40503 + 23130) ^ 16'(k >>> 3) ^ 16'(k << 9);
  endfunction

  function automatic bit rd(input logic [15:0] v, input int sel);
    return (sel < PW) ? v[sel] : 1'b0;   // R5 out-of-range reads zero
  endfunction

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = CW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < CTL) begin shd[addr] = data % 32; pend = 1; end
    else if (addr == CTL)     begin rshd = (data > MR - 1) ? MR - 1 : data; pend = 1; end
    else if (addr == CTL + 1) mask_m = data % 16;
    else if (addr == CTL + 2) value_m = data % 16;
    else if (addr == CTL + 3) armed_m = 1;
    else if (addr >= CTL + 4 && addr < CTL + 8) taps_m[addr - CTL - 4] = data % 32;
  endtask

  task automatic tick(input string tag);
    logic [15:0] v;
    logic [NP-1:0] ep;
    bit efs, etrig;
    int m;
    v = pat(kcount); kcount++;
    for (int p = 0; p < NP; p++) ep[p] = rd(v, act[p*MR + slot_m]);
    efs = (slot_m == 0);
    m = 0;
    for (int k = 0; k < DW; k++) m |= int'(rd(v, taps_m[k])) << k;
    etrig = armed_m && (((m ^ value_m) & mask_m) == 0);
    if (etrig) armed_m = 0;
    if (slot_m == ract) begin
      slot_m = 0;
      if (pend) begin
        for (int i = 0; i < 16; i++) act[i] = shd[i];
        ract = rshd; pend = 0;
      end
    end else slot_m++;
    @(negedge clk); probe_in = v; sample_en = 1'b1;
    @(negedge clk); sample_en = 1'b0;
    check(pin_valid == 1'b1, "R2 valid after tick", int'(pin_valid), 1);
    for (int p = 0; p < NP; p++)
      check(pin_out[p] == ep[p], $sformatf("%s pin%0d", tag, p), int'(pin_out[p]), int'(ep[p]));
    check(frame_start == efs, "R3 R4 frame start", int'(frame_start), int'(efs));
    check(trig == etrig, "R8 R9 trigger", int'(trig), int'(etrig));
    if (trig) fires_seen++;
    last_pins = ep;
    @(negedge clk);
    check(pin_valid == 1'b0 && pin_out == last_pins && trig == 1'b0, "R2 R8 hold between ticks",
          int'({pin_valid, trig, pin_out}), int'({2'b00, last_pins}));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin shd[i] = 31; act[i] = 31; end
    for (int k = 0; k < 4; k++) taps_m[k] = 31;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pin_out == '0 && !pin_valid && !frame_start && !trig, "R1 reset outputs",
          int'({pin_out, pin_valid, frame_start, trig}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R5: default entries read zero, frame length 1
    tick("R1 R5 default map");
    tick("R1 R5 default map");

    // ratio sweep; R10: entry address pin*8+slot, ratio at control offset 0
    for (int r = 1; r <= MR; r++) begin
      for (int p = 0; p < NP; p++)
        for (int s = 0; s < MR; s++)
          wr(p*MR + s, (p*7 + s*3 + r*5) % 24);
      wr(CTL, (r == MR) ? 20 : r - 1);   // R3 saturation at the top value
      for (int t = 0; t < 3*MR; t++) tick("R2 R5 R7 R10 pin data");
    end

    // R6: mid-frame writes stay invisible until the frame ends
    wr(CTL, 3);
    while (!(slot_m == 0 && ract == 3)) tick("R6 commit");
    tick("R6 slot0"); tick("R6 slot1");
    wr(3, (act[3] + 1) % 16);
    wr(0, (act[0] + 5) % 16);
    wr(CTL, 1);
    for (int t = 0; t < 8; t++) tick("R6 frame boundary");

    // detector: tap0 out of range, mask/value via R10 offsets
    wr(CTL + 4, 20); wr(CTL + 5, 3); wr(CTL + 6, 9); wr(CTL + 7, 14);
    wr(CTL + 1, 7); wr(CTL + 2, 4);
    for (int t = 0; t < 10; t++) tick("R9 disarmed");
    wr(CTL + 3, 1);
    for (int t = 0; t < 60; t++) begin
      tick("R8 armed");
      if (!armed_m) wr(CTL + 3, 1);
    end
    check(fires_seen > 0, "R8 trigger seen", fires_seen, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule